// File: doc/BRIEF.md
# Crossing Frame Builder with Derandomising Buffer

The block turns the channel samples of each bunch crossing into one frame for a fixed-rate serial link. A frame is one header word followed by payload words. The header carries the crossing number, a truncation flag and the number of payload words that follow. Each payload word carries one channel address and its sample value. Frames go into a 256-word buffer that absorbs the uneven frame lengths. A reader sends the buffer contents, one word per clock, whenever the link can accept data.

A configuration input selects one of three sources. Zero-suppressed frames carry only the channels above a threshold. Raw frames carry every channel. Test-pattern frames carry a fixed sequence that is used to measure link latency. A per-crossing request line can force a single raw frame while the block runs in zero-suppressed mode. When the buffer lacks room for a whole frame, the payload is cut short but the header is always written. If the buffer is completely full, the builder holds the pending header until a slot opens.

Top module: `feb_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` is 0. The first crossing after reset carries crossing number 0.
- R2: Each accepted crossing writes one header word: bit 21 = 1, bits 20:9 crossing number, bit 8 truncation flag, bits 7:0 payload word count. Exactly that many payload words follow it: bit 21 = 0, bits 20:13 = 0, bits 12:6 channel address, bits 5:0 value.
- R3: The crossing number advances by one on every `bx_valid` and wraps from 4095 to 0. A `bx_reset` pulse loads `bx_preset`, and the next crossing carries that value.
- R4: When `mode` is 0 or 3 and `raw_req` is low, the payload holds exactly the channels whose value is strictly greater than `thr`, in ascending channel order. Channel i is `hit_data[6i+5:6i]`.
- R5: When `raw_req` is high together with `bx_valid` and `mode` is 0, that one crossing's payload holds every channel in ascending order. The next crossing without the request is suppressed again.
- R6: When `mode` is 1, every frame is raw, and `raw_req` and `thr` have no effect on it.
- R7: When `mode` is 2, every frame carries N_CH payload words. Word i has channel i and value (i mod 64) XOR 0x2A. `hit_data`, `thr` and `raw_req` have no effect.
- R8: When the header is written with F free buffer words, the payload keeps min(n, F-1) of its n selected words. The lowest channels are kept. The count field gives the kept number, and the flag is 1 exactly when words were dropped.
- R9: A header is never dropped. With the buffer full, the builder waits and writes the header as soon as a word frees.
- R10: `out_valid` is high whenever the buffer holds a word. The word on `out_data` is consumed in a cycle where `out_valid` and `link_ready` are both high. It stays unchanged while unconsumed, and words leave in the order they were written.
- R11: A `bx_valid` that arrives while a frame is still being written produces no frame, but it still advances the crossing number.
- R12: The buffer is never written when full, so no stored word is overwritten or lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bx_valid | input | 1 | One-cycle strobe marking a bunch crossing |
| bx_reset | input | 1 | Loads the crossing counter from `bx_preset` |
| bx_preset | input | 12 | Value loaded by `bx_reset` |
| raw_req | input | 1 | Requests a raw frame for this crossing |
| mode | input | 2 | 0/3 suppressed, 1 raw, 2 test pattern |
| thr | input | 6 | Zero-suppression threshold |
| hit_data | input | N_CH*6 | Channel samples, channel i at bits 6i+5:6i |
| link_ready | input | 1 | Link accepts a word this cycle |
| out_valid | output | 1 | Buffer holds a word |
| out_data | output | 22 | Oldest buffered word |

## Verification
Zero-suppressed frames are tried with every channel below the threshold, every channel above it, a mixed pattern, and values exactly at the threshold. These cases separate a correct strict comparison from an off-by-one comparison and from a wrong channel order. Raw and test-pattern frames are fed hit data that would give a different payload in any other source, so a wrong source selection appears in the words that come out. With the link stalled, a run of fixed-length frames fills the buffer to a known occupancy. This shows a partly truncated frame, a header-only frame, and a header held back until a slot frees. Stop-and-go link readiness during the drain checks word order and that the head word holds steady.

// File: rtl/feb_pkg.sv
package feb_pkg;

    localparam int BXID_W = 12;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 7;
    localparam int VAL_W  = 6;
    localparam int WORD_W = 1 + BXID_W + 1 + CNT_W;
    localparam int PAD_W  = WORD_W - 1 - ADDR_W - VAL_W;

    localparam logic [VAL_W-1:0] TEST_SEED = 6'h2A;

    localparam logic [1:0] MODE_ZS   = 2'd0;
    localparam logic [1:0] MODE_RAW  = 2'd1;
    localparam logic [1:0] MODE_TEST = 2'd2;

    typedef enum logic [1:0] {
        SRC_ZS   = 2'd0,
        SRC_RAW  = 2'd1,
        SRC_TEST = 2'd2
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } bld_state_e;

    typedef struct packed {
        logic              is_hdr;
        logic [BXID_W-1:0] bxid;
        logic              trunc;
        logic [CNT_W-1:0]  count;
    } hdr_word_t;

    typedef struct packed {
        logic              is_hdr;
        logic [PAD_W-1:0]  pad;
        logic [ADDR_W-1:0] chan;
        logic [VAL_W-1:0]  val;
    } pay_word_t;

    function automatic src_e pick_src(input logic [1:0] mode, input logic raw_req);
        src_e s;
        case (mode)
            MODE_TEST: s = SRC_TEST;
            MODE_RAW:  s = SRC_RAW;
            MODE_ZS:   s = raw_req ? SRC_RAW : SRC_ZS;
            default:   s = raw_req ? SRC_RAW : SRC_ZS;
        endcase
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] make_hdr(input logic [BXID_W-1:0] bx,
                                                   input logic trunc,
                                                   input logic [CNT_W-1:0] count);
        hdr_word_t h;
        h.is_hdr = 1'b1;
        h.bxid   = bx;
        h.trunc  = trunc;
        h.count  = count;
        return h;
    endfunction

    function automatic logic [WORD_W-1:0] make_pay(input logic [ADDR_W-1:0] chan,
                                                   input logic [VAL_W-1:0] val);
        pay_word_t p;
        p.is_hdr = 1'b0;
        p.pad    = '0;
        p.chan   = chan;
        p.val    = val;
        return p;
    endfunction

endpackage

// File: rtl/feb_bxid_ctr.sv
module feb_bxid_ctr
    import feb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bx_valid,
    input  logic              bx_reset,
    input  logic [BXID_W-1:0] preset,
    output logic [BXID_W-1:0] bxid
);

    always_ff @(posedge clk) begin
        if (rst)
            bxid <= '0;
        else if (bx_reset)
            bxid <= preset;
        else if (bx_valid)
            bxid <= bxid + 1'b1;
    end

    // R3
    bxid_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bx_valid && !bx_reset) |=> (bxid == $past(bxid) + 1'b1));

    // R3
    bxid_load_chk: assert property (@(posedge clk) disable iff (rst)
        bx_reset |=> (bxid == $past(preset)));

endmodule

// File: rtl/feb_derand.sv
module feb_derand #(
    parameter  int DEPTH = 256,
    parameter  int WIDTH = 22,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             empty,
    output logic [OCC_W-1:0] occ,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push)
                wr_ptr <= wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign empty   = (occ == '0);
    assign rd_data = mem[rd_ptr];

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (occ < OCC_W'(DEPTH)));

    // R10
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty && !pop) |=> (rd_data == $past(rd_data)));

endmodule

// File: rtl/feb_builder.sv
module feb_builder
    import feb_pkg::*;
#(
    parameter  int N_CH  = 16,
    parameter  int DEPTH = 256,
    localparam int OCC_W = $clog2(DEPTH) + 1,
    localparam int IDX_W = $clog2(N_CH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bx_valid,
    input  logic                  raw_req,
    input  logic [1:0]            mode,
    input  logic [VAL_W-1:0]      thr,
    input  logic [N_CH*VAL_W-1:0] hit_data,
    input  logic [BXID_W-1:0]     bxid,
    input  logic [OCC_W-1:0]      occ,
    output logic                  wr_en,
    output logic [WORD_W-1:0]     wr_word
);

    bld_state_e                  state;
    logic [N_CH-1:0][VAL_W-1:0]  cap_vals;
    logic [VAL_W-1:0]            cap_thr;
    logic [BXID_W-1:0]           cap_bx;
    src_e                        cap_src;
    logic [IDX_W-1:0]            idx;
    logic [OCC_W-1:0]            remaining;

    logic [N_CH-1:0]             sel;
    logic [OCC_W-1:0]            hit_cnt;
    logic [OCC_W-1:0]            free_slots;
    logic [OCC_W-1:0]            room;
    logic [OCC_W-1:0]            kept;
    logic                        buf_full;
    logic [VAL_W-1:0]            pay_val;

    // Channel selection for the captured crossing and the number selected.
    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < N_CH; i++) begin
            sel[i]  = (cap_src == SRC_ZS) ? (cap_vals[i] > cap_thr) : 1'b1;
            hit_cnt = hit_cnt + OCC_W'(sel[i]);
        end
    end

    // Room left after the header decides how much payload survives.
    assign buf_full   = (occ == OCC_W'(DEPTH));
    assign free_slots = OCC_W'(DEPTH) - occ;
    assign room       = buf_full ? '0 : free_slots - 1'b1;
    assign kept       = (hit_cnt < room) ? hit_cnt : room;
    assign pay_val    = (cap_src == SRC_TEST) ? (VAL_W'(idx) ^ TEST_SEED) : cap_vals[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cap_vals  <= '0;
            cap_thr   <= '0;
            cap_bx    <= '0;
            cap_src   <= SRC_ZS;
            idx       <= '0;
            remaining <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (bx_valid) begin
                        cap_vals <= hit_data;
                        cap_thr  <= thr;
                        cap_bx   <= bxid;
                        cap_src  <= pick_src(mode, raw_req);
                        state    <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (!buf_full) begin
                        remaining <= kept;
                        idx       <= '0;
                        state     <= (kept == '0) ? ST_IDLE : ST_PAY;
                    end
                end
                ST_PAY: begin
                    idx <= idx + 1'b1;
                    if (sel[idx]) begin
                        remaining <= remaining - 1'b1;
                        if (remaining == OCC_W'(1))
                            state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_word = '0;
        if (state == ST_HDR && !buf_full) begin
            wr_en   = 1'b1;
            wr_word = make_hdr(cap_bx, (kept != hit_cnt), CNT_W'(kept));
        end else if (state == ST_PAY && sel[idx]) begin
            wr_en   = 1'b1;
            wr_word = make_pay(ADDR_W'(idx), pay_val);
        end
    end

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && bx_valid) |=> $stable(cap_bx));

    // R9
    hdr_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HDR && occ == OCC_W'(DEPTH)) |=> (state == ST_HDR));

    // R2
    pay_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_word[WORD_W-1]) |-> (state == ST_PAY && remaining != '0));

endmodule

// File: rtl/feb_top.sv
module feb_top
    import feb_pkg::*;
#(
    parameter int N_CH  = 16,
    parameter int DEPTH = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bx_valid,
    input  logic                  bx_reset,
    input  logic [BXID_W-1:0]     bx_preset,
    input  logic                  raw_req,
    input  logic [1:0]            mode,
    input  logic [VAL_W-1:0]      thr,
    input  logic [N_CH*VAL_W-1:0] hit_data,
    input  logic                  link_ready,
    output logic                  out_valid,
    output logic [WORD_W-1:0]     out_data
);

    localparam int OCC_W = $clog2(DEPTH) + 1;

    logic [BXID_W-1:0] bxid;
    logic              wr_en;
    logic [WORD_W-1:0] wr_word;
    logic              empty;
    logic [OCC_W-1:0]  occ;
    logic              pop;

    feb_bxid_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .bx_valid (bx_valid),
        .bx_reset (bx_reset),
        .preset   (bx_preset),
        .bxid     (bxid)
    );

    feb_builder #(.N_CH(N_CH), .DEPTH(DEPTH)) u_bld (
        .clk      (clk),
        .rst      (rst),
        .bx_valid (bx_valid),
        .raw_req  (raw_req),
        .mode     (mode),
        .thr      (thr),
        .hit_data (hit_data),
        .bxid     (bxid),
        .occ      (occ),
        .wr_en    (wr_en),
        .wr_word  (wr_word)
    );

    feb_derand #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en),
        .push_data (wr_word),
        .pop       (pop),
        .empty     (empty),
        .occ       (occ),
        .rd_data   (out_data)
    );

    assign out_valid = !empty;
    assign pop       = link_ready && !empty;

endmodule

// File: tb/sim_feb_top.sv
module sim_feb_top;

    localparam int N_CH  = 16;
    localparam int DEPTH = 256;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                bx_valid = 1'b0;
    logic                bx_reset = 1'b0;
    logic [11:0]         bx_preset = '0;
    logic                raw_req = 1'b0;
    logic [1:0]          mode = 2'd0;
    logic [5:0]          thr = 6'd31;
    logic [N_CH*6-1:0]   hit_data = '0;
    logic                link_ready = 1'b1;
    logic                out_valid;
    logic [21:0]         out_data;

    logic [21:0] expq [0:4095];
    int qh = 0;
    int qt = 0;
    int checks = 0;
    int fails = 0;
    int exp_bx = 0;
    int occ_m = 0;
    bit track_occ = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R1";

    feb_top #(.N_CH(N_CH), .DEPTH(DEPTH)) u0 (
        .clk        (clk),
        .rst        (rst),
        .bx_valid   (bx_valid),
        .bx_reset   (bx_reset),
        .bx_preset  (bx_preset),
        .raw_req    (raw_req),
        .mode       (mode),
        .thr        (thr),
        .hit_data   (hit_data),
        .link_ready (link_ready),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    initial forever #2 clk = ~clk;

    // Word-by-word comparison at the link side.
    always @(negedge clk) begin
        if (!rst && out_valid && link_ready) begin
            checks++;
            if (qh == qt) begin
                fails++;
                $display("FAIL %s: unexpected word %h, expected none", cur_req, out_data);
            end else begin
                if (out_data !== expq[qh]) begin
                    fails++;
                    $display("FAIL %s: word %0d got %h expected %h", cur_req, qh, out_data, expq[qh]);
                end
                qh++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [N_CH*6-1:0] mkhits(input int a, input int b);
        logic [N_CH*6-1:0] h;
        for (int i = 0; i < N_CH; i++)
            h[i*6 +: 6] = 6'((i * a + b) % 64);
        return h;
    endfunction

    function automatic logic [N_CH*6-1:0] flat(input logic [5:0] v);
        logic [N_CH*6-1:0] h;
        for (int i = 0; i < N_CH; i++)
            h[i*6 +: 6] = v;
        return h;
    endfunction

    // Model of one frame, enqueued in the order the link must see it.
    task automatic expect_frame(input logic [N_CH*6-1:0] hits, input logic rq);
        bit          sel [N_CH];
        logic [5:0]  val [N_CH];
        int n = 0;
        int kept;
        int free_w;
        int room;
        int done_w = 0;
        for (int i = 0; i < N_CH; i++) begin
            if (mode == 2'd2) begin
                sel[i] = 1'b1;
                val[i] = 6'(i) ^ 6'h2A;
            end else if (mode == 2'd1 || rq) begin
                sel[i] = 1'b1;
                val[i] = hits[i*6 +: 6];
            end else begin
                sel[i] = hits[i*6 +: 6] > thr;
                val[i] = hits[i*6 +: 6];
            end
            if (sel[i]) n++;
        end
        kept = n;
        if (track_occ) begin
            free_w = DEPTH - occ_m;
            room = (free_w == 0) ? 0 : free_w - 1;
            kept = (n < room) ? n : room;
            occ_m = (free_w == 0) ? DEPTH : occ_m + kept + 1;
        end
        expq[qt] = {1'b1, 12'(exp_bx), (kept < n), 8'(kept)};
        qt++;
        for (int i = 0; i < N_CH; i++) begin
            if (sel[i] && done_w < kept) begin
                expq[qt] = {1'b0, 8'h00, 7'(i), val[i]};
                qt++;
                done_w++;
            end
        end
    endtask

    task automatic crossing(input logic [N_CH*6-1:0] hits, input logic rq);
        expect_frame(hits, rq);
        hit_data = hits;
        raw_req  = rq;
        bx_valid = 1'b1;
        tick(1);
        bx_valid = 1'b0;
        raw_req  = 1'b0;
        exp_bx   = (exp_bx + 1) % 4096;
        tick(N_CH + 4);
    endtask

    task automatic drain(input string req);
        int guard = 0;
        link_ready = 1'b1;
        while (qh != qt && guard < 3000) begin
            tick(1);
            guard++;
        end
        tick(4);
        check(req, 32'(qh), 32'(qt));
        check(req, 32'(out_valid), 32'd0);
    endtask

    task automatic t_reset();
        cur_req = "R1";
        rst = 1'b1;
        tick(5);
        check("R1", 32'(out_valid), 32'd0);
        rst = 1'b0;
        tick(1);
        check("R1", 32'(out_valid), 32'd0);
        exp_bx = 0;
        mode = 2'd0;
        thr = 6'd31;
        crossing(mkhits(7, 3), 1'b0);
        drain("R1");
    endtask

    task automatic t_suppress();
        cur_req = "R4";
        mode = 2'd0;
        thr = 6'd31;
        crossing(flat(6'd0), 1'b0);
        crossing(flat(6'd63), 1'b0);
        crossing(mkhits(7, 3), 1'b0);
        crossing(flat(6'd31), 1'b0);
        thr = 6'd62;
        crossing(mkhits(13, 50), 1'b0);
        cur_req = "R2";
        thr = 6'd0;
        crossing(mkhits(5, 0), 1'b0);
        drain("R4");
    endtask

    task automatic t_raw_req();
        cur_req = "R5";
        mode = 2'd0;
        thr = 6'd40;
        crossing(mkhits(11, 9), 1'b1);
        crossing(mkhits(11, 9), 1'b0);
        mode = 2'd3;
        crossing(mkhits(3, 20), 1'b0);
        drain("R5");
    endtask

    task automatic t_raw_mode();
        cur_req = "R6";
        mode = 2'd1;
        thr = 6'd63;
        crossing(mkhits(9, 1), 1'b0);
        thr = 6'd0;
        crossing(mkhits(9, 1), 1'b1);
        drain("R6");
    endtask

    task automatic t_test_pattern();
        cur_req = "R7";
        mode = 2'd2;
        thr = 6'd63;
        crossing(mkhits(17, 4), 1'b0);
        thr = 6'd5;
        crossing(flat(6'd0), 1'b1);
        drain("R7");
        mode = 2'd0;
    endtask

    task automatic t_bxid();
        cur_req = "R3";
        mode = 2'd0;
        thr = 6'd31;
        bx_preset = 12'd4094;
        bx_reset = 1'b1;
        tick(1);
        bx_reset = 1'b0;
        exp_bx = 4094;
        tick(2);
        crossing(mkhits(7, 3), 1'b0);
        crossing(mkhits(7, 3), 1'b0);
        crossing(mkhits(7, 3), 1'b0);
        drain("R3");
    endtask

    task automatic t_busy();
        cur_req = "R11";
        mode = 2'd1;
        expect_frame(mkhits(2, 7), 1'b0);
        hit_data = mkhits(2, 7);
        bx_valid = 1'b1;
        tick(1);
        bx_valid = 1'b0;
        tick(2);
        hit_data = flat(6'd5);
        bx_valid = 1'b1;
        tick(1);
        bx_valid = 1'b0;
        exp_bx = (exp_bx + 2) % 4096;
        tick(N_CH + 4);
        crossing(mkhits(4, 1), 1'b0);
        drain("R11");
        mode = 2'd0;
    endtask

    task automatic t_readout();
        cur_req = "R10";
        mode = 2'd0;
        thr = 6'd20;
        link_ready = 1'b0;
        crossing(mkhits(7, 3), 1'b0);
        crossing(mkhits(5, 11), 1'b0);
        crossing(flat(6'd63), 1'b0);
        check("R10", 32'(out_valid), 32'd1);
        check("R10", 32'(out_data), 32'(expq[qh]));
        tick(3);
        check("R10", 32'(out_data), 32'(expq[qh]));
        for (int c = 0; c < 120; c++) begin
            link_ready = (c % 3) != 0;
            tick(1);
        end
        drain("R10");
    endtask

    task automatic t_trunc();
        logic [N_CH*6-1:0] five;
        cur_req = "R8";
        link_ready = 1'b0;
        track_occ = 1'b1;
        occ_m = 0;
        mode = 2'd1;
        for (int k = 0; k < 14; k++)
            crossing(mkhits(k + 1, k), 1'b0);
        mode = 2'd0;
        thr = 6'd31;
        five = flat(6'd10);
        for (int i = 0; i < 5; i++)
            five[i*6 +: 6] = 6'd40;
        crossing(five, 1'b0);
        mode = 2'd1;
        crossing(mkhits(3, 7), 1'b0);
        cur_req = "R9";
        crossing(mkhits(6, 2), 1'b0);
        check("R12", 32'(out_valid), 32'd1);
        check("R12", 32'(out_data), 32'(expq[qh]));
        track_occ = 1'b0;
        cur_req = "R12";
        drain("R9");
        mode = 2'd0;
    endtask

    initial begin
        t_reset();
        t_suppress();
        t_raw_req();
        t_raw_mode();
        t_test_pattern();
        t_bxid();
        t_busy();
        t_readout();
        t_trunc();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule